// File: doc/BRIEF.md
# Absolute to Physical Address Mapper

This block turns a 64-bit absolute address into a physical address when virtual translation is switched off. Two mode inputs pick the rule. With the wide-mode flag set, the address is cut to the implemented physical width and sign-extended from its top bit. With the wide-mode flag clear, only the low 32 bits count, and the top byte of that word picks one of three regions. Ordinary memory is zero-extended. The I/O window is sign-extended. The firmware window is zero-extended and then has every bit from `PA_BITS-4` upward forced to one.

A legacy-architecture flag turns off the region split for narrow accesses, so that those addresses are simply zero-extended. A 2-bit region tag comes out with each result. An optional output register, chosen by a parameter, gives one cycle of latency and carries a valid bit. The physical width `PA_BITS` is a parameter that may not exceed 54 bits. It must also be at least 36, so that the firmware high bits sit above the 32-bit window.

Top module: `amap_top`

## Requirements
- R1: With `wide_mode`=1, `phys_addr` equals bits `PA_BITS-1:0` of `abs_addr`, sign-extended from bit `PA_BITS-1` to 64 bits, and `region` is 3. This holds whatever the value of `legacy_arch`.
- R2: With `wide_mode`=0, `legacy_arch`=0 and `abs_addr[31:28]` not equal to 4'hF, `phys_addr` is `abs_addr[31:0]` zero-extended and `region` is 0 (memory).
- R3: With `wide_mode`=0, `legacy_arch`=0, `abs_addr[31:28]`=4'hF and `abs_addr[27:24]` nonzero, `phys_addr` is `abs_addr[31:0]` sign-extended to 64 bits and `region` is 1 (I/O).
- R4: With `wide_mode`=0, `legacy_arch`=0 and `abs_addr[31:24]`=8'hF0, `phys_addr` is `abs_addr[31:0]` zero-extended with bits 63 down to `PA_BITS-4` set to one, and `region` is 2 (firmware).
- R5: With `wide_mode`=0 and `legacy_arch`=1, `phys_addr` is `abs_addr[31:0]` zero-extended and `region` is 0, for every value of bits 31:24, including 8'hF0 and 8'hF5.
- R6: With `wide_mode`=0, bits 63:32 of `abs_addr` have no effect on `phys_addr` or `region`.
- R7: With `REG_OUT`=1, a result shows on the outputs one clock after the edge that samples `in_valid`=1, and `out_valid` equals `in_valid` delayed by one cycle. While `rst` is high, `out_valid`, `phys_addr` and `region` are zero.
- R8: With `REG_OUT`=1, a cycle with `in_valid`=0 leaves `phys_addr` and `region` unchanged, even when `abs_addr` or the mode inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input address qualifier |
| abs_addr | input | 64 | Absolute address |
| wide_mode | input | 1 | Wide addressing mode |
| legacy_arch | input | 1 | Legacy architecture level: no narrow region split |
| out_valid | output | 1 | Result qualifier |
| phys_addr | output | 64 | Mapped physical address, extended to 64 bits |
| region | output | 2 | 0 memory, 1 I/O, 2 firmware, 3 wide |

## Verification
The bench tests the edges of the region decode. It uses 0xEFFFFFFF, which is memory only because bits 31:28 fall short of all ones. It uses 0xF1000000 and 0xFFFFFFFF, the lowest and highest I/O words, and 0xF0000000 and 0xF0FFFFFF, the two ends of the firmware window. A decoder that looked at the wrong nibble, or treated the firmware window as I/O, would return sign-extended ones where there should be zeros and would report the wrong region. In wide mode, addresses with bit `PA_BITS-1` set and clear expose a sign extension taken from the wrong bit. Garbage in the high half of narrow addresses, and the legacy flag applied to firmware and I/O words, catch a mapper that lets those inputs through. Idle cycles with changing inputs catch an output register that loads without `in_valid`.

// File: rtl/amap_pkg.sv
package amap_pkg;
  localparam int ABS_W = 64;

  typedef enum logic [1:0] {
    RG_MEM  = 2'd0,
    RG_IO   = 2'd1,
    RG_FW   = 2'd2,
    RG_WIDE = 2'd3
  } region_e;
endpackage

// File: rtl/amap_region_decode.sv
module amap_region_decode
  import amap_pkg::*;
(
  input  logic [31:0] low_word,
  input  logic        wide_mode,
  input  logic        legacy_arch,
  output region_e     region
);
  logic top_nib_ones;
  logic sub_nib_zero;

  assign top_nib_ones = (low_word[31:28] == 4'hF);
  assign sub_nib_zero = (low_word[27:24] == 4'h0);

  always_comb begin
    if (wide_mode)         region = RG_WIDE;
    else if (legacy_arch)  region = RG_MEM;
    else if (!top_nib_ones) region = RG_MEM;
    else if (!sub_nib_zero) region = RG_IO;
    else                   region = RG_FW;
  end
endmodule

// File: rtl/amap_extend.sv
module amap_extend
  import amap_pkg::*;
#(
  parameter int PA_BITS = 40
) (
  input  logic [ABS_W-1:0] abs_addr,
  input  region_e          region,
  output logic [ABS_W-1:0] phys_addr
);
  localparam int WIDE_PAD = ABS_W - PA_BITS;
  localparam int FW_LSB   = PA_BITS - 4;
  localparam logic [ABS_W-1:0] FW_MASK = ~((64'd1 << FW_LSB) - 64'd1);

  logic [ABS_W-1:0] zext32;
  logic [ABS_W-1:0] sext32;
  logic [ABS_W-1:0] sext_pa;

  assign zext32  = {32'd0, abs_addr[31:0]};
  assign sext32  = {{32{abs_addr[31]}}, abs_addr[31:0]};
  assign sext_pa = {{WIDE_PAD{abs_addr[PA_BITS-1]}}, abs_addr[PA_BITS-1:0]};

  always_comb begin
    unique case (region)
      RG_WIDE: phys_addr = sext_pa;
      RG_IO:   phys_addr = sext32;
      RG_FW:   phys_addr = zext32 | FW_MASK;
      default: phys_addr = zext32;
    endcase
  end
endmodule

// File: rtl/amap_out_stage.sv
module amap_out_stage #(
  parameter int W       = 66,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_r;
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          v_r <= 1'b0;
          q_r <= '0;
        end else begin
          v_r <= d_valid;
          if (d_valid) q_r <= d;
        end
      end
      assign q_valid = v_r;
      assign q       = q_r;

      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q_valid == $past(d_valid))); // R7
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!d_valid && !$past(rst)) |=> $stable(q)); // R8
    end else begin : g_pass
      assign q_valid = d_valid;
      assign q       = d;
    end
  endgenerate
endmodule

// File: rtl/amap_top.sv
module amap_top
  import amap_pkg::*;
#(
  parameter int PA_BITS = 40,
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [63:0] abs_addr,
  input  logic        wide_mode,
  input  logic        legacy_arch,
  output logic        out_valid,
  output logic [63:0] phys_addr,
  output logic [1:0]  region
);
  localparam int STAGE_W = ABS_W + 2;

  generate
    if (PA_BITS > 54 || PA_BITS < 36) begin : g_bad_width
      $error("amap_top: PA_BITS must lie in 36..54");
    end
  endgenerate

  region_e          rg_c;
  logic [ABS_W-1:0] pa_c;
  logic [STAGE_W-1:0] stage_q;

  amap_region_decode u_dec (
    .low_word    (abs_addr[31:0]),
    .wide_mode   (wide_mode),
    .legacy_arch (legacy_arch),
    .region      (rg_c)
  );

  amap_extend #(.PA_BITS(PA_BITS)) u_ext (
    .abs_addr  (abs_addr),
    .region    (rg_c),
    .phys_addr (pa_c)
  );

  amap_out_stage #(.W(STAGE_W), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d       ({rg_c, pa_c}),
    .q_valid (out_valid),
    .q       (stage_q)
  );

  assign region    = stage_q[STAGE_W-1 -: 2];
  assign phys_addr = stage_q[ABS_W-1:0];

  AST_WIDE_SIGN: assert property (@(posedge clk) disable iff (rst)
    (rg_c == RG_WIDE) |-> (pa_c[63:PA_BITS-1] == {(65-PA_BITS){abs_addr[PA_BITS-1]}})); // R1
  AST_MEM_ZERO_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rg_c == RG_MEM) |-> (pa_c[63:32] == 32'd0)); // R2
  AST_IO_ONES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rg_c == RG_IO) |-> (&pa_c[63:31])); // R3
  AST_FW_ONES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rg_c == RG_FW) |-> ((&pa_c[63:PA_BITS-4]) && pa_c[31:24] == 8'hF0)); // R4
  AST_LEGACY_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && legacy_arch) |-> (rg_c == RG_MEM)); // R5
  AST_NARROW_LOW_KEPT: assert property (@(posedge clk) disable iff (rst)
    !wide_mode |-> (pa_c[31:0] == abs_addr[31:0])); // R6
endmodule

// File: tb/amap_top_tb_top.sv
module amap_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PA_BITS = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] abs_addr = '0;
  logic        wide_mode = 1'b0;
  logic        legacy_arch = 1'b0;
  logic        out_valid;
  logic [63:0] phys_addr;
  logic [1:0]  region;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amap_top #(.PA_BITS(PA_BITS), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .abs_addr(abs_addr),
    .wide_mode(wide_mode), .legacy_arch(legacy_arch),
    .out_valid(out_valid), .phys_addr(phys_addr), .region(region)
  );

  function automatic logic [63:0] model_pa(logic [63:0] a, logic w, logic l);
    logic [63:0] z;
    z = {32'd0, a[31:0]};
    if (w) return {{(64-PA_BITS){a[PA_BITS-1]}}, a[PA_BITS-1:0]};
    if (l) return z;
    if (a[31:28] != 4'hF) return z;
    if (a[27:24] != 4'h0) return {{32{a[31]}}, a[31:0]};
    return z | ~((64'd1 << (PA_BITS-4)) - 64'd1);
  endfunction

  function automatic logic [1:0] model_rg(logic [63:0] a, logic w, logic l);
    if (w) return 2'd3;
    if (l) return 2'd0;
    if (a[31:28] != 4'hF) return 2'd0;
    if (a[27:24] != 4'h0) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one register).
  task automatic map_one(string req, logic [63:0] a, logic w, logic l);
    @(negedge clk);
    abs_addr = a; wide_mode = w; legacy_arch = l; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_eq({req, " pa"}, phys_addr, model_pa(a, w, l));
    check_eq({req, " region"}, {62'd0, region}, {62'd0, model_rg(a, w, l)});
    check_eq({req, " valid"}, {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_reset;
    check_eq("R7 reset valid", {63'd0, out_valid}, 64'd0);
    check_eq("R7 reset pa", phys_addr, 64'd0);
    check_eq("R7 reset region", {62'd0, region}, 64'd0);
  endtask

  task automatic t_wide;
    map_one("R1 wide bit39 set", 64'h1234_5688_0000_0ABC, 1'b1, 1'b0);
    check_eq("R1 wide neg literal", phys_addr, 64'hFFFF_FF88_0000_0ABC);
    map_one("R1 wide bit39 clear", 64'hFFFF_FF70_F000_0001, 1'b1, 1'b0);
    map_one("R1 wide legacy", 64'h0000_00F0_F012_3456, 1'b1, 1'b1);
  endtask

  task automatic t_narrow;
    map_one("R2 mem low", 64'h0000_0000_0000_1000, 1'b0, 1'b0);
    map_one("R2 mem edge", 64'h0000_0000_EFFF_FFFF, 1'b0, 1'b0);
    map_one("R3 io lowest", 64'h0000_0000_F100_0000, 1'b0, 1'b0);
    map_one("R3 io highest", 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0);
    check_eq("R3 io literal", phys_addr, 64'hFFFF_FFFF_FFFF_FFFF);
    map_one("R4 fw base", 64'h0000_0000_F000_0000, 1'b0, 1'b0);
    check_eq("R4 fw literal", phys_addr, 64'hFFFF_FFF0_F000_0000);
    map_one("R4 fw top", 64'h0000_0000_F0FF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_legacy;
    map_one("R5 legacy fw word", 64'h0000_0000_F012_3456, 1'b0, 1'b1);
    map_one("R5 legacy io word", 64'h0000_0000_F500_0001, 1'b0, 1'b1);
  endtask

  task automatic t_high_ignored;
    map_one("R6 mem high junk", 64'hDEAD_BEEF_1234_5678, 1'b0, 1'b0);
    check_eq("R6 mem literal", phys_addr, 64'h0000_0000_1234_5678);
    map_one("R6 io high junk", 64'h5A5A_0000_F300_0010, 1'b0, 1'b0);
    map_one("R6 fw high junk", 64'hFFFF_FFFF_F000_0044, 1'b0, 1'b0);
  endtask

  task automatic t_latency_hold;
    logic [63:0] held_pa;
    logic [1:0]  held_rg;
    map_one("R7 prime", 64'h0000_0000_F000_0100, 1'b0, 1'b0);
    held_pa = phys_addr; held_rg = region;
    // Idle cycles with changing inputs: outputs must hold (R8).
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      abs_addr = 64'h0000_0000_F700_0000 + i; wide_mode = i[0]; legacy_arch = 1'b0;
    end
    @(negedge clk);
    check_eq("R8 hold pa", phys_addr, held_pa);
    check_eq("R8 hold region", {62'd0, region}, {62'd0, held_rg});
    check_eq("R7 valid low idle", {63'd0, out_valid}, 64'd0);
    // New request: before the edge the old result remains (R7 latency).
    abs_addr = 64'h0000_0000_0000_0040; wide_mode = 1'b0; in_valid = 1'b1;
    #1;
    check_eq("R7 not before edge", phys_addr, held_pa);
    @(negedge clk);
    in_valid = 1'b0;
    check_eq("R7 after one edge", phys_addr, 64'h40);
    check_eq("R7 valid one cycle", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check_eq("R7 valid drops", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_wide();
    t_narrow();
    t_legacy();
    t_high_ignored();
    t_latency_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule